// File: doc/BRIEF.md
# HDLC Shared-Bus Access Controller

This block lets one station share an open-collector (wired-OR) serial line with other stations that send HDLC frames. While the station waits, the block watches the line level on a clear-to-send input and counts the idle ones in a row. A frame may start only when that run reaches a threshold. The threshold is 8 in the normal state and 10 right after the station has sent a frame successfully, so a neighbour that is waiting gets the line first.

While a frame is on the line, every bit that goes out on TXD is compared with the line level read back at mid-bit. A recessive 1 that reads back as 0 means another station is driving the line. The bit in progress is completed, TXD goes back to recessive, and the framer is told to rewind its frame so that it can be sent again once the line is idle. A failed attempt made under the 10-ones rule puts the station back on the 8-ones rule.

The framer hands over one bit at a time, together with a last-bit marker, and advances when it sees a take pulse. Bit timing comes from two one-cycle enable strobes in the system clock domain. TXD changes on the falling-edge strobe, and the line is sampled on the rising-edge strobe.

Top module: `hdlc_bus_access`

## Requirements
- R1: While the station is not transmitting, each rising strobe adds one to the idle-run count if the line reads 1 and clears the count if the line reads 0.
- R2: In high priority, with a request present, transmission starts on the first falling strobe after 8 consecutive ones have been sampled. On that strobe TXD takes the framer's first bit and busy rises.
- R3: When the bit marked last is sampled without a collision, done pulses for exactly one cycle after that rising strobe. The station then enters low priority and needs 10 consecutive ones before its next start.
- R4: A collision during an attempt started in low priority returns the station to the 8-ones threshold. A collision during a high-priority attempt leaves the threshold at 8.
- R5: TXD carries the framer's bits in order, one per bit period. Each bit is latched on a falling strobe that also produces a one-cycle bit_take pulse.
- R6: TXD changes only in the cycle after a falling strobe. The idle-run count changes only on rising strobes or when transmission clears it.
- R7: When a transmitted 1 is read back as 0 at the rising strobe, collision pulses for one cycle. The frame ends at the next falling strobe.
- R8: A transmitted 0 that reads back as 0 is not a collision, and the frame continues.
- R9: frame_rewind pulses in the same cycle as collision, and no further bit is taken for the aborted attempt.
- R10: TXD is 1 and busy is 0 whenever no frame is being sent, including right after a collision abort.
- R11: Without a request, no transmission starts, however long the line stays idle.
- R12: After reset, TXD is 1 and busy, done, collision, bit_take and frame_rewind are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_fall | input | 1 | One-cycle strobe at the falling edge of the bit clock |
| bit_rise | input | 1 | One-cycle strobe at the rising edge of the bit clock (mid-bit) |
| cts_in | input | 1 | Line level read back from the wired-OR bus |
| tx_req | input | 1 | Framer has a frame pending |
| tx_bit | input | 1 | Current frame bit offered by the framer |
| tx_last | input | 1 | Offered bit is the last of the frame |
| bit_take | output | 1 | Offered bit was latched; framer advances |
| frame_rewind | output | 1 | Framer restarts the frame from its first bit |
| txd | output | 1 | Serial data to the line (1 = recessive) |
| busy | output | 1 | A frame is being sent |
| done | output | 1 | One-cycle pulse: frame sent without collision |
| collision | output | 1 | One-cycle pulse: collision detected |

## Verification
A wrong idle-run count or a wrong priority state appears at the ports as a start on the wrong falling strobe. The bench therefore measures, for every attempt, how many idle ones were sampled before busy rose, and this exposes the fault within one frame gap. A stale latched bit or a missed comparison appears either as a TXD bit that differs from the framer's sequence, visible in that same bit period, or as a collision or done pulse that the scoreboard did not expect, visible one cycle after the rising strobe. A bad end-of-frame state leaves TXD low or busy high after the closing falling strobe, and this is checked in the next cycle.

// File: rtl/hdlc_bus_pkg.sv
package hdlc_bus_pkg;
  typedef enum logic {
    LINK_WAIT = 1'b0,
    LINK_SEND = 1'b1
  } link_state_e;
endpackage

// File: rtl/hdlc_idle_run.sv
module hdlc_idle_run #(
  parameter int SAT   = 10,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_en,
  input  logic             clr,
  input  logic             line_bit,
  input  logic [CNT_W-1:0] thr,
  output logic             run_ok
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SAT);

  logic [CNT_W-1:0] count_q, count_d;

  always_comb begin
    count_d = count_q;
    if (clr) begin
      count_d = '0;
    end else if (sample_en) begin
      if (!line_bit)
        count_d = '0;
      else if (count_q != CNT_MAX)
        count_d = count_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  assign run_ok = (count_q >= thr);

  // R1: a zero on the line restarts the run
  p_zero_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && !line_bit |=> count_q == '0);
  // R1: a one extends the run until saturation
  p_one_extends_r1: assert property (@(posedge clk) disable iff (!rst_n)
    sample_en && line_bit && !clr && (count_q != CNT_MAX) |=> count_q == $past(count_q) + 1'b1);
  // R6: between rising strobes the run holds
  p_run_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_en && !clr |=> $stable(count_q));
endmodule

// File: rtl/hdlc_access_prio.sv
module hdlc_access_prio #(
  parameter int HI_RUN = 8,
  parameter int LO_RUN = 10,
  parameter int CNT_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             done_evt,
  input  logic             coll_evt,
  output logic [CNT_W-1:0] thr
);
  logic low_q, low_d;

  always_comb begin
    low_d = low_q;
    if (done_evt)      low_d = 1'b1;
    else if (coll_evt) low_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_q <= 1'b0;
    else        low_q <= low_d;
  end

  assign thr = low_q ? CNT_W'(LO_RUN) : CNT_W'(HI_RUN);

  // R3: success lowers priority
  p_done_lowers_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> thr == CNT_W'(LO_RUN));
  // R4: a collision always leaves the short threshold in force
  p_coll_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
    coll_evt && !done_evt |=> thr == CNT_W'(HI_RUN));
endmodule

// File: rtl/hdlc_tx_engine.sv
module hdlc_tx_engine
  import hdlc_bus_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic bit_fall,
  input  logic bit_rise,
  input  logic cts_in,
  input  logic run_ok,
  input  logic tx_req,
  input  logic tx_bit,
  input  logic tx_last,
  output logic bit_take,
  output logic frame_rewind,
  output logic txd,
  output logic busy,
  output logic done,
  output logic collision
);
  link_state_e state_q, state_d;
  logic cur_bit_q, cur_bit_d;
  logic cur_last_q, cur_last_d;
  logic end_q, end_d;
  logic txd_q, txd_d;
  logic take_q, take_d;
  logic done_q, done_d;
  logic coll_q, coll_d;

  always_comb begin
    state_d    = state_q;
    cur_bit_d  = cur_bit_q;
    cur_last_d = cur_last_q;
    end_d      = end_q;
    txd_d      = txd_q;
    take_d     = 1'b0;
    done_d     = 1'b0;
    coll_d     = 1'b0;
    case (state_q)
      LINK_WAIT: begin
        txd_d = 1'b1;
        if (bit_fall && tx_req && run_ok) begin
          state_d    = LINK_SEND;
          txd_d      = tx_bit;
          cur_bit_d  = tx_bit;
          cur_last_d = tx_last;
          take_d     = 1'b1;
          end_d      = 1'b0;
        end
      end
      LINK_SEND: begin
        if (bit_rise && !end_q) begin
          if (cur_bit_q && !cts_in) begin
            coll_d = 1'b1;
            end_d  = 1'b1;
          end else if (cur_last_q) begin
            done_d = 1'b1;
            end_d  = 1'b1;
          end
        end
        if (bit_fall) begin
          if (end_q) begin
            state_d = LINK_WAIT;
            txd_d   = 1'b1;
            end_d   = 1'b0;
          end else begin
            txd_d      = tx_bit;
            cur_bit_d  = tx_bit;
            cur_last_d = tx_last;
            take_d     = 1'b1;
          end
        end
      end
      default: state_d = LINK_WAIT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= LINK_WAIT;
      cur_bit_q  <= 1'b1;
      cur_last_q <= 1'b0;
      end_q      <= 1'b0;
      txd_q      <= 1'b1;
      take_q     <= 1'b0;
      done_q     <= 1'b0;
      coll_q     <= 1'b0;
    end else begin
      state_q    <= state_d;
      cur_bit_q  <= cur_bit_d;
      cur_last_q <= cur_last_d;
      end_q      <= end_d;
      txd_q      <= txd_d;
      take_q     <= take_d;
      done_q     <= done_d;
      coll_q     <= coll_d;
    end
  end

  assign bit_take     = take_q;
  assign frame_rewind = coll_q;
  assign txd          = txd_q;
  assign busy         = (state_q == LINK_SEND);
  assign done         = done_q;
  assign collision    = coll_q;

  // R6: strobes never coincide, TXD moves only after a falling strobe
  p_strobes_apart_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(bit_rise && bit_fall));
  p_txd_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_fall |=> $stable(txd_q));
  // R2: a start needs a request and a full idle run at a falling strobe
  p_start_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(bit_fall && tx_req && run_ok));
  // R7: collision is a single-cycle pulse caused by a 1 read back as 0
  p_coll_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    coll_q |=> !coll_q);
  p_coll_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(coll_q) |-> $past(bit_rise && cur_bit_q && !cts_in));
  // R8: a sent zero is never a collision
  p_zero_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bit_rise && (state_q == LINK_SEND) && !cur_bit_q |=> !coll_q);
  // R10: line recessive when idle
  p_idle_recessive_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> txd_q);
  // R3: done and collision exclude each other
  p_one_outcome_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(done_q && coll_q));
endmodule

// File: rtl/hdlc_bus_access.sv
module hdlc_bus_access #(
  parameter int HI_RUN = 8,
  parameter int LO_RUN = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_fall,
  input  logic bit_rise,
  input  logic cts_in,
  input  logic tx_req,
  input  logic tx_bit,
  input  logic tx_last,
  output logic bit_take,
  output logic frame_rewind,
  output logic txd,
  output logic busy,
  output logic done,
  output logic collision
);
  localparam int RUN_MAX = (LO_RUN > HI_RUN) ? LO_RUN : HI_RUN;
  localparam int CNT_W   = $clog2(RUN_MAX + 1);

  logic [CNT_W-1:0] thr;
  logic             run_ok;
  logic             busy_w;
  logic             done_w;
  logic             coll_w;

  hdlc_idle_run #(.SAT(RUN_MAX), .CNT_W(CNT_W)) u_run (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_en (bit_rise && !busy_w),
    .clr       (busy_w),
    .line_bit  (cts_in),
    .thr       (thr),
    .run_ok    (run_ok)
  );

  hdlc_access_prio #(.HI_RUN(HI_RUN), .LO_RUN(LO_RUN), .CNT_W(CNT_W)) u_prio (
    .clk      (clk),
    .rst_n    (rst_n),
    .done_evt (done_w),
    .coll_evt (coll_w),
    .thr      (thr)
  );

  hdlc_tx_engine u_eng (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_fall     (bit_fall),
    .bit_rise     (bit_rise),
    .cts_in       (cts_in),
    .run_ok       (run_ok),
    .tx_req       (tx_req),
    .tx_bit       (tx_bit),
    .tx_last      (tx_last),
    .bit_take     (bit_take),
    .frame_rewind (frame_rewind),
    .txd          (txd),
    .busy         (busy_w),
    .done         (done_w),
    .collision    (coll_w)
  );

  assign busy      = busy_w;
  assign done      = done_w;
  assign collision = coll_w;

  // R9: no bit is taken in the cycle a collision is reported
  p_no_take_on_coll_r9: assert property (@(posedge clk) disable iff (!rst_n)
    collision |-> !bit_take);
endmodule

// File: tb/test_hdlc_bus_access.sv
`timescale 1ns/1ps
module test_hdlc_bus_access;
  logic clk, rst_n;
  logic fall_s, rise_s, other_lvl, tx_req;
  logic [31:0] frame_bits;
  int frame_len, idx;
  logic tx_bit, tx_last, cts;
  logic bit_take, frame_rewind, txd, busy, done, collision;

  typedef enum {EV_DONE, EV_COLL} ev_e;
  ev_e exp_q[$];
  logic sent_q[$];
  int take_cnt;
  int n_chk, n_fail;
  bit finished;
  logic fall_seen;

  initial clk = 1'b0;
  always #4 clk = ~clk;

  assign cts     = txd & other_lvl;
  assign tx_bit  = (idx < frame_len) ? frame_bits[idx] : 1'b1;
  assign tx_last = (idx == frame_len - 1);

  hdlc_bus_access i_hdlc_bus_access (
    .clk(clk), .rst_n(rst_n), .bit_fall(fall_s), .bit_rise(rise_s),
    .cts_in(cts), .tx_req(tx_req), .tx_bit(tx_bit), .tx_last(tx_last),
    .bit_take(bit_take), .frame_rewind(frame_rewind), .txd(txd),
    .busy(busy), .done(done), .collision(collision)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // capture line-side values at the edge the design uses
  always @(posedge clk) begin
    fall_seen <= fall_s;
    if (rst_n && rise_s && busy) sent_q.push_back(txd);
  end

  // monitor: framer model and scoreboard
  logic txd_prev;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bit_take) begin idx++; take_cnt++; end
      if (frame_rewind) idx = 0;
      if (frame_rewind || collision)
        check(frame_rewind == collision, "R9 rewind with collision", frame_rewind, collision);
      if (txd !== txd_prev)
        check(fall_seen, "R6 txd moved off falling strobe", 0, 1);
      if (done || collision) begin
        if (exp_q.size() == 0) begin
          check(0, "R3/R7 unexpected outcome pulse", done ? 0 : 1, -1);
        end else begin
          ev_e e;
          e = exp_q.pop_front();
          check((done && e == EV_DONE) || (collision && e == EV_COLL),
                "R3/R7 outcome kind", done ? 0 : 1, (e == EV_DONE) ? 0 : 1);
        end
      end
    end
    txd_prev = txd;
  end

  task automatic do_fall();
    @(negedge clk) fall_s = 1'b1;
    @(negedge clk) fall_s = 1'b0;
  endtask
  task automatic do_rise();
    @(negedge clk) rise_s = 1'b1;
    @(negedge clk) rise_s = 1'b0;
  endtask

  task automatic wait_access(input int exp_n, input int pre_ones, input string tag);
    int n;
    bool_dummy: begin end
    other_lvl = 1'b0;
    for (int i = 0; i < 2; i++) begin do_fall(); do_rise(); end
    if (pre_ones > 0) begin
      other_lvl = 1'b1;
      for (int i = 0; i < pre_ones; i++) begin do_fall(); do_rise(); end
      other_lvl = 1'b0;
      do_fall(); do_rise();
      check(!busy, "R1 start before full run", busy, 0);
    end
    other_lvl = 1'b1;
    n = 0;
    for (int i = 0; i < 20; i++) begin
      do_fall();
      if (busy) break;
      do_rise();
      n++;
    end
    check(n == exp_n, tag, n, exp_n);
    check(busy && txd == frame_bits[0], "R2 first bit on start", txd, frame_bits[0]);
  endtask

  task automatic run_frame(input logic [31:0] bits, input int len, input int low_idx,
                           input bit exp_coll, input int exp_n, input int pre_ones,
                           input string tag);
    int nsent;
    frame_bits = bits; frame_len = len; idx = 0;
    take_cnt = 0;
    sent_q.delete();
    exp_q.push_back(exp_coll ? EV_COLL : EV_DONE);
    wait_access(exp_n, pre_ones, tag);
    for (int k = 0; k < 40; k++) begin
      other_lvl = (k == low_idx) ? 1'b0 : 1'b1;
      do_rise();
      other_lvl = 1'b1;
      do_fall();
      if (!busy) break;
    end
    nsent = exp_coll ? low_idx + 1 : len;
    check(exp_q.size() == 0, exp_coll ? "R7 collision reported" : "R3 done reported",
          exp_q.size(), 0);
    exp_q.delete();
    check(sent_q.size() == nsent, "R5 bit count on line", sent_q.size(), nsent);
    for (int k = 0; k < sent_q.size() && k < nsent; k++)
      if (sent_q[k] !== bits[k]) check(0, "R5 bit value", sent_q[k], bits[k]);
    check(take_cnt == nsent, "R5 take pulses", take_cnt, nsent);
    check(txd && !busy, "R10 idle after frame", {txd, busy}, 2);
    if (exp_coll) check(idx == 0, "R9 framer rewound", idx, 0);
  endtask

  initial begin
    n_chk = 0; n_fail = 0; finished = 0;
    rst_n = 1'b0; fall_s = 0; rise_s = 0; other_lvl = 1; tx_req = 0;
    frame_bits = '0; frame_len = 0; idx = 0; take_cnt = 0; txd_prev = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(txd && !busy && !done && !collision && !bit_take && !frame_rewind,
          "R12 reset state", {txd, busy, done, collision, bit_take, frame_rewind}, 32);
    tx_req = 1'b1;
    run_frame(32'hA5, 8, -1, 0, 8, 0, "R2 high priority needs 8 ones");
    run_frame(32'hFF, 8, 1, 1, 10, 0, "R3 low priority needs 10 ones");
    run_frame(32'h5A, 8, 2, 0, 8, 5, "R4 back to 8 after low collision (R1 R8)");
    run_frame(32'h3C, 8, -1, 0, 10, 0, "R3 low priority after success");
    run_frame(32'hF0, 8, 5, 1, 10, 0, "R3 low priority before collision");
    run_frame(32'h0F, 8, 3, 1, 8, 0, "R4 high priority attempt collides");
    run_frame(32'hC96, 12, -1, 0, 8, 0, "R4 high collision keeps 8");
    tx_req = 1'b0;
    other_lvl = 1'b1;
    for (int i = 0; i < 14; i++) begin do_fall(); do_rise(); end
    check(!busy && txd, "R11 no start without request", busy, 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule